// File: doc/BRIEF.md
# TDM Timeslot-to-Channel Compressor

This block turns a 32-timeslot serial frame of 256 bits into a 193-bit serial frame made of one framing bit followed by 24 eight-bit channels. A 32-bit drop mask chooses which input timeslots are thrown away. The surviving timeslots are packed in rising timeslot order into output channels 1 to 24. Both sides are serial streams with a per-bit strobe and a frame-start marker, and they run in one clock domain.

The input side assembles each received timeslot into a byte and writes it into one half of a two-frame ping-pong memory. When a frame completes, that half becomes the readable half and writing moves to the other half. At each output frame start, the output side captures the newest completed half and the mask waiting to be applied. It then serialises the packed channels. The framing bit is always a one, and any channel with no timeslot behind it carries all ones.

Top module: `tdm_ch_compress`

## Requirements
- R1: An input frame is 32 timeslots of 8 bits, MSb first, one bit per `in_strobe`. `in_fsync` is high together with the strobe of timeslot 1's MSb. After 256 bits without a marker, a new frame starts by itself.
- R2: An output frame is 193 bit positions, one per `out_strobe`. Position 0 is the framing bit, and positions 1+8(c-1) to 8c carry channel c MSb first. A strobe with `out_fsync` high, or the strobe after position 192, starts a frame.
- R3: The framing-bit position of every output frame is 1.
- R4: Mask bit i (bit 0 is timeslot 1, bit 31 is timeslot 32) set to 1 discards timeslot i+1, and its data never appears on the output.
- R5: Kept timeslots fill output channels 1, 2, ... in ascending timeslot order.
- R6: After reset the mask is 0xFF000000, so timeslots 1 to 24 appear on channels 1 to 24.
- R7: When fewer than 24 timeslots are kept, the unfilled trailing channels are all ones.
- R8: When more than 24 timeslots are kept, only the 24 lowest-numbered ones are sent.
- R9: A mask write (`mask_we` with `mask_wdata`) has no effect on the output frame in progress. It takes effect from the next output frame start.
- R10: An output frame carries the most recently completed input frame.
- R11: While in reset and in the first cycle after it, `out_data` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| in_strobe | input | 1 | Input bit valid |
| in_fsync | input | 1 | Input frame start, with first bit |
| in_data | input | 1 | Input serial data |
| out_strobe | input | 1 | Output bit advance |
| out_fsync | input | 1 | Output frame start (framing-bit slot) |
| out_data | output | 1 | Registered output serial data |
| mask_we | input | 1 | Drop-mask write enable |
| mask_wdata | input | 32 | Drop-mask value, bit i = timeslot i+1 |

## Verification
The default mask gives a plain one-to-one mapping, so it shows whether ordering and alignment are right. The split mask 0xFC010001 shows that dropped slots are skipped in the middle of the frame and at its head. An all-kept mask separates dropping the highest excess timeslots from dropping the wrong ones. Alternating and all-dropped masks show whether the trailing channels are filled with all ones. Randomized masks and data show packing against an independent model. Directed runs then change the mask in the middle of a frame and write two input frames before one output frame, which tells apart deferred mask application and reading of the newest buffer half.

// File: rtl/tdm_cc_pkg.sv
package tdm_cc_pkg;
  localparam int          DEF_SLOTS = 32;
  localparam int          DEF_CHANS = 24;
  localparam int          DEF_BITS  = 8;
  localparam logic [31:0] DEF_MASK  = 32'hFF00_0000;

  // output-side bit event classification
  typedef enum logic [1:0] {
    EV_IDLE,
    EV_FRAME,
    EV_CHAN,
    EV_SHIFT
  } pk_ev_e;
endpackage

// File: rtl/tdm_in_writer.sv
module tdm_in_writer #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_strobe,
  input  logic                       in_fsync,
  input  logic                       in_data,
  output logic                       wr_en,
  output logic [$clog2(SLOTS):0]     wr_addr,
  output logic [BITS-1:0]            wr_data,
  output logic                       ready_bank
);
  localparam int IW   = $clog2(SLOTS*BITS);
  localparam int BW   = $clog2(BITS);
  localparam int LAST = SLOTS*BITS - 1;

  logic [IW-1:0]   in_pos, p_nxt;
  logic [BITS-1:0] sh;
  logic            wbank;

  always_comb begin
    if (in_fsync || in_pos == IW'(LAST)) p_nxt = '0;
    else                                 p_nxt = in_pos + 1'b1;
    wr_en   = in_strobe && (p_nxt[BW-1:0] == {BW{1'b1}});
    wr_addr = {wbank, p_nxt[IW-1:BW]};
    wr_data = {sh[BITS-2:0], in_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pos     <= IW'(LAST);
      sh         <= '0;
      wbank      <= 1'b0;
      ready_bank <= 1'b1;
    end else if (in_strobe) begin
      in_pos <= p_nxt;
      sh     <= {sh[BITS-2:0], in_data};
      if (p_nxt == IW'(LAST)) begin
        ready_bank <= wbank;
        wbank      <= ~wbank;
      end
    end
  end

  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (rst)
    (in_strobe && !in_fsync && in_pos == IW'(LAST-1)) |=> (wbank != $past(wbank))); // R10
endmodule

// File: rtl/tdm_pp_ram.sv
module tdm_pp_ram #(
  parameter int AW   = 6,
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [BITS-1:0] wr_data,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [BITS-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [BITS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tdm_out_packer.sv
module tdm_out_packer
  import tdm_cc_pkg::*;
#(
  parameter int          SLOTS    = 32,
  parameter int          CHANS    = 24,
  parameter int          BITS     = 8,
  parameter logic [31:0] RST_MASK = 32'hFF00_0000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   out_strobe,
  input  logic                   out_fsync,
  input  logic                   mask_we,
  input  logic [SLOTS-1:0]       mask_wdata,
  input  logic                   ready_bank,
  output logic                   rd_en,
  output logic [$clog2(SLOTS):0] rd_addr,
  input  logic [BITS-1:0]        rd_data,
  output logic                   out_data
);
  localparam int FRAME = 1 + CHANS*BITS;
  localparam int PW    = $clog2(FRAME);
  localparam int SW    = $clog2(SLOTS);
  localparam int CW    = $clog2(CHANS+1);

  pk_ev_e           ev;
  logic [PW-1:0]    pos, pos_nxt;
  logic [SLOTS-1:0] pend_mask, act_mask, use_mask;
  logic [SW:0]      ptr, from;
  logic [CW-1:0]    cnt;
  logic             rb, use_bank, have_q, found;
  logic [SW-1:0]    pick;
  logic [BITS-1:0]  sh;

  always_comb begin
    ev      = EV_IDLE;
    pos_nxt = pos;
    if (out_strobe) begin
      if (out_fsync || pos == PW'(FRAME-1)) begin
        ev      = EV_FRAME;
        pos_nxt = '0;
      end else begin
        pos_nxt = pos + 1'b1;
        ev = (((pos_nxt - 1'b1) & PW'(BITS-1)) == '0) ? EV_CHAN : EV_SHIFT;
      end
    end
    use_mask = (ev == EV_FRAME) ? pend_mask  : act_mask;
    use_bank = (ev == EV_FRAME) ? ready_bank : rb;
    from     = (ev == EV_FRAME) ? '0         : ptr;
    found = 1'b0;
    pick  = '0;
    for (int i = SLOTS-1; i >= 0; i--) begin
      if (!use_mask[i] && (SW+1)'(i) >= from) begin
        found = 1'b1;
        pick  = SW'(i);
      end
    end
    rd_en   = (ev == EV_FRAME) || (ev == EV_CHAN && cnt < CW'(CHANS));
    rd_addr = {use_bank, pick};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= PW'(FRAME-1);
      pend_mask <= RST_MASK[SLOTS-1:0];
      act_mask  <= RST_MASK[SLOTS-1:0];
      ptr       <= '0;
      cnt       <= '0;
      rb        <= 1'b0;
      have_q    <= 1'b0;
      sh        <= '1;
      out_data  <= 1'b1;
    end else begin
      if (mask_we) pend_mask <= mask_wdata;
      pos <= pos_nxt;
      if (rd_en) begin
        have_q <= found;
        if (found)                ptr <= {1'b0, pick} + 1'b1;
        else if (ev == EV_FRAME)  ptr <= '0;
      end
      case (ev)
        EV_FRAME: begin
          act_mask <= pend_mask;
          rb       <= ready_bank;
          cnt      <= CW'(1);
          out_data <= 1'b1;
        end
        EV_CHAN: begin
          if (cnt < CW'(CHANS)) cnt <= cnt + 1'b1;
          out_data <= have_q ? rd_data[BITS-1] : 1'b1;
          sh       <= have_q ? {rd_data[BITS-2:0], 1'b1} : '1;
        end
        EV_SHIFT: begin
          out_data <= sh[BITS-1];
          sh       <= {sh[BITS-2:0], 1'b1};
        end
        default: ;
      endcase
    end
  end

  AST_FBIT_ONE: assert property (@(posedge clk) disable iff (rst)
    (out_strobe && out_fsync) |=> out_data); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ev != EV_FRAME) |=> $stable(act_mask)); // R9
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos <= PW'(FRAME-1)); // R2
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> out_data); // R11
endmodule

// File: rtl/tdm_ch_compress.sv
module tdm_ch_compress
  import tdm_cc_pkg::*;
#(
  parameter int          SLOTS    = DEF_SLOTS,
  parameter int          CHANS    = DEF_CHANS,
  parameter int          BITS     = DEF_BITS,
  parameter logic [31:0] RST_MASK = DEF_MASK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_strobe,
  input  logic             in_fsync,
  input  logic             in_data,
  input  logic             out_strobe,
  input  logic             out_fsync,
  output logic             out_data,
  input  logic             mask_we,
  input  logic [SLOTS-1:0] mask_wdata
);
  localparam int AW = $clog2(SLOTS) + 1;

  logic            wr_en, rd_en, ready_bank;
  logic [AW-1:0]   wr_addr, rd_addr;
  logic [BITS-1:0] wr_data, rd_data;

  tdm_in_writer #(.SLOTS(SLOTS), .BITS(BITS)) u_wr (
    .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_fsync(in_fsync),
    .in_data(in_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ready_bank(ready_bank)
  );

  tdm_pp_ram #(.AW(AW), .BITS(BITS)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  tdm_out_packer #(.SLOTS(SLOTS), .CHANS(CHANS), .BITS(BITS), .RST_MASK(RST_MASK)) u_pk (
    .clk(clk), .rst(rst), .out_strobe(out_strobe), .out_fsync(out_fsync),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .ready_bank(ready_bank),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .out_data(out_data)
  );
endmodule

// File: tb/tdm_ch_compress_tb.sv
module tdm_ch_compress_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_strobe = 1'b0, in_fsync = 1'b0, in_data = 1'b0;
  logic        out_strobe = 1'b0, out_fsync = 1'b0;
  logic        mask_we = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic        out_data;

  int n_chk = 0, n_bad = 0;
  logic [31:0]  rng = 32'h1234_5678;
  logic [7:0]   fb [32];
  logic [192:0] exp_f, got_f;

  always #10 clk = ~clk;

  tdm_ch_compress u_dut (
    .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_fsync(in_fsync),
    .in_data(in_data), .out_strobe(out_strobe), .out_fsync(out_fsync),
    .out_data(out_data), .mask_we(mask_we), .mask_wdata(mask_wdata)
  );

  // masks: default (R6), split example (R4,R5), all kept (R8),
  // alternating (R7), all dropped (R7), upper half kept, sparse, lower dropped
  localparam logic [31:0] VEC_MASK [8] = '{
    32'hFF00_0000, 32'hFC01_0001, 32'h0000_0000, 32'hAAAA_AAAA,
    32'hFFFF_FFFF, 32'h0000_FFFF, 32'h7777_7777, 32'h0000_00FF
  };

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [192:0] g, input logic [192:0] e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, g, e);
    end
  endtask

  task automatic fill_frame();
    for (int s = 0; s < 32; s++) begin
      rng = nxt(rng);
      fb[s] = rng[7:0];
    end
  endtask

  // reference packing; bit 192 = framing bit, then channels MSb first
  task automatic model(input logic [31:0] m);
    int ch = 0;
    exp_f = '1;
    for (int s = 0; s < 32; s++) begin
      if (!m[s] && ch < 24) begin
        for (int b = 0; b < 8; b++) exp_f[191 - ch*8 - b] = fb[s][7-b];
        ch++;
      end
    end
  endtask

  task automatic write_mask(input logic [31:0] m);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = m;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic send_frame();
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      in_strobe = 1'b1; in_fsync = (p == 0); in_data = fb[p/8][7 - p%8];
    end
    @(negedge clk);
    in_strobe = 1'b0; in_fsync = 1'b0;
  endtask

  // one bit per two cycles; optional mask write at bit 100
  task automatic recv_frame(input bit mid_wr, input logic [31:0] mid_m);
    for (int k = 0; k < 193; k++) begin
      @(negedge clk);
      out_strobe = 1'b1; out_fsync = (k == 0);
      if (mid_wr && k == 100) begin mask_we = 1'b1; mask_wdata = mid_m; end
      @(negedge clk);
      out_strobe = 1'b0; out_fsync = 1'b0; mask_we = 1'b0;
      got_f[192-k] = out_data;
    end
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] m;
    logic [7:0]  keep_b [32];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_data === 1'b1, "R11 reset out_data", {192'b0, out_data}, 193'b1);

    // default mask without any write (R6)
    fill_frame(); send_frame(); recv_frame(0, '0);
    model(32'hFF00_0000);
    check(got_f === exp_f, "R6 default mapping", got_f, exp_f);
    check(got_f[192] === 1'b1, "R3 framing bit", {192'b0, got_f[192]}, 193'b1);

    for (int v = 0; v < 8; v++) begin
      write_mask(VEC_MASK[v]);
      fill_frame(); send_frame(); recv_frame(0, '0);
      model(VEC_MASK[v]);
      check(got_f === exp_f, "R1/R2/R4/R5/R7/R8 table mask", got_f, exp_f);
    end

    for (int r = 0; r < 5; r++) begin
      rng = nxt(rng); m = rng;
      if (r[0]) m = m & nxt(rng);
      write_mask(m);
      fill_frame(); send_frame(); recv_frame(0, '0);
      model(m);
      check(got_f === exp_f, "R4/R5 random mask", got_f, exp_f);
    end

    // R10: two input frames, output shows the second
    write_mask(32'hFC01_0001);
    fill_frame(); send_frame();
    fill_frame(); send_frame();
    recv_frame(0, '0);
    model(32'hFC01_0001);
    check(got_f === exp_f, "R10 newest input frame", got_f, exp_f);

    // R9: mid-frame write leaves current frame alone, applies at next
    for (int s = 0; s < 32; s++) keep_b[s] = fb[s];
    recv_frame(1, 32'h0000_0000);
    model(32'hFC01_0001);
    check(got_f === exp_f, "R9 write deferred", got_f, exp_f);
    recv_frame(0, '0);
    for (int s = 0; s < 32; s++) fb[s] = keep_b[s];
    model(32'h0000_0000);
    check(got_f === exp_f, "R9 write applied next frame", got_f, exp_f);
    check(got_f[192] === 1'b1, "R3 framing bit after change", {192'b0, got_f[192]}, 193'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule